// File: doc/BRIEF.md
# Alarm Register and Display Selector

This block sits next to the hours:minutes counter of a 24-hour alarm clock running from a 256 Hz system clock. It keeps the alarm setting as four BCD digits, copying them from the keypad entry buffer on a single-cycle strobe from the clock's controller and holding them at all other times. It also routes one of three four-digit values to the display path. When the controller asks to show digits being keyed in, those digits are shown. When it asks to show the alarm, the stored alarm setting is shown. Otherwise the running time is shown.

While the running time matches the alarm setting on all four digits, the block drives a 128 Hz square wave to the speaker. It also drives a seconds lamp that blinks once per second. An active-low reset clears the alarm setting to 00:00 and silences the speaker. The reset takes effect at once, and its release is synchronised to the clock.

Top module: `alarm_display_unit`

## Requirements
- R1: While reset is asserted, and after it is released with no load, the stored alarm reads 00:00 and the speaker output is low.
- R2: When `alarm_load` is high at a rising clock edge, the stored alarm takes the value of `entry_digits` at that edge.
- R3: When `alarm_load` is low, the stored alarm keeps its value, whatever `entry_digits` does.
- R4: With `show_entry` high and `show_alarm` low, `disp_digits` equals `entry_digits`.
- R5: With `show_alarm` high and `show_entry` low, `disp_digits` equals the stored alarm.
- R6: With both selects low, `disp_digits` equals `clock_digits`.
- R7: With both selects high, `disp_digits` equals `entry_digits`, so the entry takes priority.
- R8: While `clock_digits` equals the stored alarm, `speaker` is low in the cycle the match begins and then inverts after every rising edge (1, 0, 1, ...).
- R9: Whenever any one of the four digits differs, `speaker` is low at once, in the same cycle. Digit fields are minute units [3:0], minute tens [7:4], hour units [11:8] and hour tens [15:12].
- R10: `sec_led` is high for the first 128 clocks after reset and then alternates: 128 clocks low, then 128 clocks high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 256 Hz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| entry_digits | input | 16 | BCD digits from the keypad entry buffer |
| clock_digits | input | 16 | BCD digits of the running time |
| alarm_load | input | 1 | Load strobe for the alarm setting |
| show_entry | input | 1 | Select the entry digits for display |
| show_alarm | input | 1 | Select the alarm setting for display |
| disp_digits | output | 16 | Four BCD digits sent to the display |
| speaker | output | 1 | Alarm tone, 128 Hz while the times match |
| sec_led | output | 1 | Seconds lamp, 1 Hz square wave |

## Verification
The bench first drives both display selects high at once. A mux that ranks the alarm above the entry would show the alarm setting there instead of the keyed digits. It then makes the running time differ from the alarm setting in one digit only, first the minute units and then the hour tens. A comparator that skipped a digit would sound the speaker there. It ends a match while the tone is high, which catches a registered gate that leaves the speaker on one cycle too long. It also measures the exact high and low lengths of the seconds lamp, which an off-by-one count would stretch to 127 or 129.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int DIGIT_W  = 4;
  localparam int N_DIGITS = 4;

  typedef enum logic [1:0] {
    SRC_CLOCK = 2'd0,
    SRC_ALARM = 2'd1,
    SRC_ENTRY = 2'd2
  } disp_src_e;
endpackage

// File: rtl/alarm_rst_sync.sv
module alarm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/alarm_store.sv
module alarm_store #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] entry,
  output logic [TW-1:0] alarm
);
  logic [TW-1:0] alarm_q, alarm_d;

  always_comb begin
    alarm_d = alarm_q;
    if (load) alarm_d = entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alarm_q <= '0;
    else        alarm_q <= alarm_d;
  end

  assign alarm = alarm_q;

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (alarm == $past(entry)));

  // R3
  alarm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(alarm));
endmodule

// File: rtl/alarm_disp_mux.sv
module alarm_disp_mux
  import alarm_pkg::*;
#(
  parameter int DW = 4,
  parameter int ND = 4
) (
  input  logic             show_entry,
  input  logic             show_alarm,
  input  logic [DW*ND-1:0] entry_t,
  input  logic [DW*ND-1:0] alarm_t,
  input  logic [DW*ND-1:0] clock_t,
  output logic [DW*ND-1:0] disp_t
);
  disp_src_e src;

  always_comb begin
    if (show_entry)      src = SRC_ENTRY;
    else if (show_alarm) src = SRC_ALARM;
    else                 src = SRC_CLOCK;
  end

  for (genvar g = 0; g < ND; g++) begin : g_digit
    always_comb begin
      unique case (src)
        SRC_ENTRY: disp_t[g*DW +: DW] = entry_t[g*DW +: DW];
        SRC_ALARM: disp_t[g*DW +: DW] = alarm_t[g*DW +: DW];
        default:   disp_t[g*DW +: DW] = clock_t[g*DW +: DW];
      endcase
    end
  end

  // R7
  entry_prio_chk: assert final (!show_entry || disp_t == entry_t);
  // R6
  clock_default_chk: assert final (show_entry || show_alarm || disp_t == clock_t);
endmodule

// File: rtl/alarm_tone.sv
module alarm_tone #(
  parameter int DW = 4,
  parameter int ND = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW*ND-1:0] clock_t,
  input  logic [DW*ND-1:0] alarm_t,
  output logic             speaker
);
  logic [ND-1:0] digit_eq;
  logic          match;
  logic          tone_q, tone_d;

  for (genvar g = 0; g < ND; g++) begin : g_cmp
    assign digit_eq[g] = (clock_t[g*DW +: DW] == alarm_t[g*DW +: DW]);
  end

  assign match = &digit_eq;

  always_comb begin
    tone_d = 1'b0;
    if (match) tone_d = ~tone_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tone_q <= 1'b0;
    else        tone_q <= tone_d;
  end

  assign speaker = tone_q & match;

  // R8
  tone_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && $past(match)) |-> (speaker != $past(speaker)));
endmodule

// File: rtl/alarm_sec_blink.sv
module alarm_sec_blink #(
  parameter int CLK_HZ = 256
) (
  input  logic clk,
  input  logic rst_n,
  output logic led
);
  localparam int CW = $clog2(CLK_HZ);
  localparam logic [CW-1:0] LAST = CW'(CLK_HZ - 1);
  localparam logic [CW-1:0] HALF = CW'(CLK_HZ / 2);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign led = (cnt_q < HALF);

  // R10
  led_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (led != $past(led)) |-> (cnt_q == '0 || cnt_q == HALF));
endmodule

// File: rtl/alarm_display_unit.sv
module alarm_display_unit
  import alarm_pkg::*;
#(
  parameter int DW     = DIGIT_W,
  parameter int ND     = N_DIGITS,
  parameter int CLK_HZ = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW*ND-1:0] entry_digits,
  input  logic [DW*ND-1:0] clock_digits,
  input  logic             alarm_load,
  input  logic             show_entry,
  input  logic             show_alarm,
  output logic [DW*ND-1:0] disp_digits,
  output logic             speaker,
  output logic             sec_led
);
  localparam int TW = DW * ND;

  logic          rst_int_n;
  logic [TW-1:0] alarm_t;

  alarm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  alarm_store #(.TW(TW)) u_store (
    .clk   (clk),
    .rst_n (rst_int_n),
    .load  (alarm_load),
    .entry (entry_digits),
    .alarm (alarm_t)
  );

  alarm_disp_mux #(.DW(DW), .ND(ND)) u_mux (
    .show_entry (show_entry),
    .show_alarm (show_alarm),
    .entry_t    (entry_digits),
    .alarm_t    (alarm_t),
    .clock_t    (clock_digits),
    .disp_t     (disp_digits)
  );

  alarm_tone #(.DW(DW), .ND(ND)) u_tone (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clock_t (clock_digits),
    .alarm_t (alarm_t),
    .speaker (speaker)
  );

  alarm_sec_blink #(.CLK_HZ(CLK_HZ)) u_blink (
    .clk   (clk),
    .rst_n (rst_int_n),
    .led   (sec_led)
  );

  // R9
  mismatch_silent_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (clock_digits != alarm_t) |-> !speaker);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_int_n |-> (alarm_t == '0 && !speaker));
endmodule

// File: tb/tb_alarm_display_unit.sv
module tb_alarm_display_unit;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] entry_digits, clock_digits;
  logic        alarm_load, show_entry, show_alarm;
  logic [15:0] disp_digits;
  logic        speaker, sec_led;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_display_unit dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .entry_digits (entry_digits),
    .clock_digits (clock_digits),
    .alarm_load   (alarm_load),
    .show_entry   (show_entry),
    .show_alarm   (show_alarm),
    .disp_digits  (disp_digits),
    .speaker      (speaker),
    .sec_led      (sec_led)
  );

  // {show_entry, show_alarm, entry, clock, expected source: 0 clock, 1 alarm, 2 entry}
  localparam logic [35:0] VEC [6] = '{
    {1'b1, 1'b0, 16'h1245, 16'h0911, 2'd2},
    {1'b0, 1'b1, 16'h2359, 16'h0001, 2'd1},
    {1'b0, 1'b0, 16'h1800, 16'h2207, 2'd0},
    {1'b1, 1'b1, 16'h0505, 16'h1111, 2'd2},
    {1'b0, 1'b0, 16'h0000, 16'h2359, 2'd0},
    {1'b1, 1'b1, 16'h2222, 16'h0730, 2'd2}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n_lo, n_hi, guard;
    logic [15:0] exp_disp;
    rst_n = 1'b0;
    entry_digits = 16'h0000;
    clock_digits = 16'h1234;
    alarm_load = 1'b0;
    show_entry = 1'b0;
    show_alarm = 1'b1;
    repeat (3) tick();
    #1;
    check("R1 alarm in reset", disp_digits, 16'h0000);
    check("R1 speaker in reset", speaker, 0);
    rst_n = 1'b1;
    tick();
    #1;
    check("R10 led high after reset", sec_led, 1);

    // R10: measure low and high phase lengths
    guard = 0;
    while (sec_led !== 1'b0 && guard < 400) begin tick(); guard++; end
    n_lo = 0;
    while (sec_led === 1'b0 && n_lo < 400) begin tick(); n_lo++; end
    n_hi = 0;
    while (sec_led === 1'b1 && n_hi < 400) begin tick(); n_hi++; end
    check("R10 led low length", n_lo, 128);
    check("R10 led high length", n_hi, 128);
    check("R1 alarm after reset", disp_digits, 16'h0000);

    // R2: load the alarm
    entry_digits = 16'h0730;
    alarm_load = 1'b1;
    tick();
    alarm_load = 1'b0;
    entry_digits = 16'h9999;
    #1;
    check("R2 alarm loaded", disp_digits, 16'h0730);
    repeat (3) tick();
    #1;
    check("R3 alarm held without strobe", disp_digits, 16'h0730);

    // R4-R7 table walk
    for (int i = 0; i < 6; i++) begin
      tick();
      show_entry   = VEC[i][35];
      show_alarm   = VEC[i][34];
      entry_digits = VEC[i][33:18];
      clock_digits = VEC[i][17:2];
      #1;
      case (VEC[i][1:0])
        2'd2:    exp_disp = VEC[i][33:18];
        2'd1:    exp_disp = 16'h0730;
        default: exp_disp = VEC[i][17:2];
      endcase
      check($sformatf("R4 R5 R6 R7 vector %0d", i), disp_digits, exp_disp);
    end

    // R9: one digit off (minute units), then hour tens
    tick();
    show_entry = 1'b0;
    show_alarm = 1'b0;
    clock_digits = 16'h0731;
    repeat (3) tick();
    #1;
    check("R9 minute units differ", speaker, 0);
    clock_digits = 16'h1730;
    repeat (3) tick();
    #1;
    check("R9 hour tens differ", speaker, 0);

    // R8: matching tone pattern
    clock_digits = 16'h0730;
    #1;
    check("R8 speaker low on first match cycle", speaker, 0);
    for (int k = 0; k < 5; k++) begin
      tick();
      #1;
      check($sformatf("R8 tone step %0d", k), speaker, (k % 2 == 0) ? 1 : 0);
    end
    clock_digits = 16'h0731;
    #1;
    check("R9 silent same cycle at minute change", speaker, 0);
    tick();
    #1;
    check("R9 stays silent", speaker, 0);

    // R1: reset mid-run clears the alarm
    clock_digits = 16'h0730;
    repeat (2) tick();
    rst_n = 1'b0;
    show_alarm = 1'b1;
    #1;
    check("R1 async clear alarm", disp_digits, 16'h0000);
    check("R1 async clear speaker", speaker, 0);
    tick();
    rst_n = 1'b1;
    repeat (3) tick();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule